// File: doc/BRIEF.md
# Descriptor Ring Producer/Consumer Manager

This block keeps a circular queue of 16-byte request descriptors in local storage for a host controller command or transfer queue. A producer hands in the three words of a descriptor: a 64-bit parameter, a 32-bit status word and a 32-bit control word. The block replaces bit 0 of the control word with its own producer cycle state and writes the descriptor into the next free slot. It also reports how many entries are occupied and how many can still be written.

The queue holds 2^n usable slots. One more slot at the end always holds a jump descriptor that points back to the ring start. When the producer fills the last usable slot, the block writes the jump descriptor in the same cycle, marks it to toggle the cycle, and then inverts its producer cycle state. One slot is always kept empty, so at most 2^n-1 entries are occupied at once.

The consumer side advances one entry per completion and reports the index of the entry it retired most recently. A separate request forms a doorbell word from a target and a stream ID. Every slot can be read back through a combinational read port. The command queue uses n = 2 and the transfer queue uses n = 6.

Top module: `trb_ring_mgr`

## Requirements
- R1: After reset the occupied count is 0, the free count equals 2^n-1, the producer cycle state is 1, `push_full` is 0 and every slot reads as zero.
- R2: An accepted push writes slot (producer count mod 2^n). The slot receives the parameter in bits 63:0, the status in bits 95:64 and the control word in bits 127:96, with control bit 0 (cycle) replaced by the producer cycle state. Control bit 1 is toggle-cycle, bits 4, 5 and 6 are chain, interrupt-on-completion and immediate data, and bits 15:10 hold the 6-bit type. Type codes are normal 1, setup 2, data 3, status 4, jump 6, no-op 8 and command no-op 23.
- R3: The producer and consumer counts are free-running. The occupied count equals producer minus consumer, and the free count equals 2^n-1 minus the occupied count.
- R4: While the free count is 0, `push_full` is 1, and a push changes neither the counts, the cycle state nor any slot.
- R5: A push into slot 2^n-1 also writes slot 2^n with parameter = `ring_base`, status 0 and control = type 6 in bits 15:10, bit 1 set and bit 0 equal to the cycle state before the push. The producer cycle state then inverts.
- R6: A completion advances the consumer count by one while the occupied count is non-zero. A completion on an empty ring is ignored.
- R7: `last_idx` equals (consumer count - 1) AND (2^n-1).
- R8: A doorbell request gives, one cycle later, a single-cycle `db_valid` with `db_value` = target OR (stream << 16).
- R9: A push and a completion in the same cycle are both carried out, so the occupied count is unchanged.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 64 | Ring start address placed in the jump descriptor |
| push_valid | input | 1 | Push a descriptor this cycle |
| push_param | input | 64 | Descriptor parameter word |
| push_status | input | 32 | Descriptor status word |
| push_ctrl | input | 32 | Descriptor control word (bit 0 overwritten) |
| push_full | output | 1 | No free slot; a push is rejected |
| comp_valid | input | 1 | Consumer retires one entry |
| fill | output | RING_LOG2 | Occupied entries |
| remaining | output | RING_LOG2 | Free entries |
| last_idx | output | RING_LOG2 | Index of most recently consumed entry |
| cycle_state | output | 1 | Producer cycle state |
| db_req | input | 1 | Request a doorbell write |
| db_target | input | 16 | Doorbell target |
| db_stream | input | 16 | Doorbell stream ID |
| db_valid | output | 1 | Doorbell write strobe |
| db_value | output | 32 | Doorbell word |
| rd_idx | input | RING_LOG2+1 | Slot to read |
| rd_data | output | 128 | Contents of slot `rd_idx` |

## Verification
The bench runs the command-queue size (n = 2), so both wrap directions can be reached in a few pushes. It pushes descriptors while the cycle state is 1 and again while it is 0, and sets control bit 0 opposite to the cycle state, so the check sees that the stored bit comes from the block and not from the input. It pushes against a full ring and completes against an empty one to show that both are ignored. It also issues a push and a completion in the same cycle to separate a correct simultaneous update from one that gives either side priority. The jump descriptor is read after the first wrap and after the second wrap, so its cycle bit is checked in both phases.

// File: rtl/trb_ring_pkg.sv
package trb_ring_pkg;

  localparam int DESC_W   = 128;
  localparam int TYPE_LSB = 10;

  localparam logic [5:0] TYPE_NORMAL  = 6'd1;
  localparam logic [5:0] TYPE_SETUP   = 6'd2;
  localparam logic [5:0] TYPE_DATA    = 6'd3;
  localparam logic [5:0] TYPE_STATUS  = 6'd4;
  localparam logic [5:0] TYPE_JUMP    = 6'd6;
  localparam logic [5:0] TYPE_NOP     = 6'd8;
  localparam logic [5:0] TYPE_CMD_NOP = 6'd23;

  localparam int CTL_CYCLE  = 0;
  localparam int CTL_TOGGLE = 1;
  localparam int CTL_CHAIN  = 4;
  localparam int CTL_IOC    = 5;
  localparam int CTL_IMM    = 6;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] stat;
    logic [63:0] param;
  } desc_t;

  // Replace the cycle bit of a descriptor with the producer state.
  function automatic desc_t stamp_cycle(desc_t d, logic cyc);
    desc_t r;
    r = d;
    r.ctrl[CTL_CYCLE] = cyc;
    return r;
  endfunction

  // Build the jump descriptor that closes the ring.
  function automatic desc_t make_jump(logic [63:0] base, logic cyc);
    desc_t r;
    r.param = base;
    r.stat  = '0;
    r.ctrl  = '0;
    r.ctrl[TYPE_LSB +: 6] = TYPE_JUMP;
    r.ctrl[CTL_TOGGLE]    = 1'b1;
    r.ctrl[CTL_CYCLE]     = cyc;
    return r;
  endfunction

  // Doorbell word: target in low half, stream ID in high half.
  function automatic logic [31:0] bell_word(logic [15:0] target, logic [15:0] stream);
    return {stream, 16'h0000} | {16'h0000, target};
  endfunction

endpackage

// File: rtl/trb_ring_ptrs.sv
module trb_ring_ptrs #(
  parameter int RING_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_go,
  input  logic                 comp_go,
  output logic [RING_LOG2-1:0] prod,
  output logic [RING_LOG2-1:0] fill,
  output logic [RING_LOG2-1:0] remaining,
  output logic [RING_LOG2-1:0] last_idx,
  output logic                 cycle_state,
  output logic                 wrap_evt
);

  localparam logic [RING_LOG2-1:0] MASK = {RING_LOG2{1'b1}};

  logic [RING_LOG2-1:0] cons;

  // Counters are n bits wide; differences are taken modulo 2^n, which
  // is exact because the occupied count never exceeds 2^n-1.
  function automatic logic [RING_LOG2-1:0] occ_of(logic [RING_LOG2-1:0] p,
                                                  logic [RING_LOG2-1:0] c);
    return p - c;
  endfunction

  function automatic logic [RING_LOG2-1:0] free_of(logic [RING_LOG2-1:0] f);
    return MASK - f;
  endfunction

  function automatic logic [RING_LOG2-1:0] prev_of(logic [RING_LOG2-1:0] c);
    return c - 1'b1;
  endfunction

  assign fill      = occ_of(prod, cons);
  assign remaining = free_of(fill);
  assign last_idx  = prev_of(cons);
  assign wrap_evt  = push_go && (prod == MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod        <= '0;
      cons        <= '0;
      cycle_state <= 1'b1;
    end else begin
      if (push_go) prod <= prod + 1'b1;
      if (comp_go) cons <= cons + 1'b1;
      if (wrap_evt) cycle_state <= ~cycle_state;
    end
  end

endmodule

// File: rtl/trb_ring_store.sv
module trb_ring_store
  import trb_ring_pkg::*;
#(
  parameter int RING_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RING_LOG2-1:0] wr_idx,
  input  desc_t                wr_data,
  input  logic                 jump_en,
  input  desc_t                jump_data,
  input  logic [RING_LOG2:0]   rd_idx,
  output desc_t                rd_data
);

  localparam int USABLE = 2 ** RING_LOG2;
  localparam int DEPTH  = USABLE + 1;

  desc_t slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    desc_t q;
    if (g < USABLE) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en && (wr_idx == RING_LOG2'(g))) q <= wr_data;
      end
    end else begin : g_jump
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (jump_en) q <= jump_data;
      end
    end
    assign slots[g] = q;
  end

  always_comb begin
    if (int'(rd_idx) < DEPTH) rd_data = slots[rd_idx];
    else                      rd_data = '0;
  end

endmodule

// File: rtl/trb_ring_bell.sv
module trb_ring_bell
  import trb_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [15:0] target,
  input  logic [15:0] stream,
  output logic        valid,
  output logic [31:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      value <= '0;
    end else begin
      valid <= req;
      if (req) value <= bell_word(target, stream);
    end
  end

endmodule

// File: rtl/trb_ring_mgr.sv
module trb_ring_mgr
  import trb_ring_pkg::*;
#(
  parameter int RING_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [63:0]          ring_base,
  input  logic                 push_valid,
  input  logic [63:0]          push_param,
  input  logic [31:0]          push_status,
  input  logic [31:0]          push_ctrl,
  output logic                 push_full,
  input  logic                 comp_valid,
  output logic [RING_LOG2-1:0] fill,
  output logic [RING_LOG2-1:0] remaining,
  output logic [RING_LOG2-1:0] last_idx,
  output logic                 cycle_state,
  input  logic                 db_req,
  input  logic [15:0]          db_target,
  input  logic [15:0]          db_stream,
  output logic                 db_valid,
  output logic [31:0]          db_value,
  input  logic [RING_LOG2:0]   rd_idx,
  output logic [127:0]         rd_data
);

  logic [RING_LOG2-1:0] prod;
  logic                 push_go;
  logic                 comp_go;
  logic                 wrap_evt;
  desc_t                push_desc;
  desc_t                jump_desc;
  desc_t                rd_desc;

  assign push_full = (remaining == '0);
  assign push_go   = push_valid && !push_full;
  assign comp_go   = comp_valid && (fill != '0);

  assign push_desc = stamp_cycle({push_ctrl, push_status, push_param}, cycle_state);
  assign jump_desc = make_jump(ring_base, cycle_state);

  trb_ring_ptrs #(.RING_LOG2(RING_LOG2)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_go     (push_go),
    .comp_go     (comp_go),
    .prod        (prod),
    .fill        (fill),
    .remaining   (remaining),
    .last_idx    (last_idx),
    .cycle_state (cycle_state),
    .wrap_evt    (wrap_evt)
  );

  trb_ring_store #(.RING_LOG2(RING_LOG2)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (push_go),
    .wr_idx    (prod),
    .wr_data   (push_desc),
    .jump_en   (wrap_evt),
    .jump_data (jump_desc),
    .rd_idx    (rd_idx),
    .rd_data   (rd_desc)
  );

  assign rd_data = rd_desc;

  trb_ring_bell u_bell (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (db_req),
    .target (db_target),
    .stream (db_stream),
    .valid  (db_valid),
    .value  (db_value)
  );

endmodule

// File: rtl/trb_ring_chk.sv
module trb_ring_chk #(
  parameter int RING_LOG2 = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 push_valid,
  input logic                 push_full,
  input logic                 comp_valid,
  input logic [RING_LOG2-1:0] fill,
  input logic                 cycle_state,
  input logic                 wrap_evt,
  input logic                 db_req,
  input logic                 db_valid
);

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_full && !comp_valid) |=> (fill == RING_LOG2'($past(fill) + 1'b1))); // R3

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_full && !comp_valid) |=> $stable(fill)); // R4

  AST_CYCLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cycle_state != $past(cycle_state))); // R5

  AST_CYCLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(cycle_state)); // R5

  AST_EMPTY_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_valid && (fill == '0) && !push_valid) |=> (fill == '0)); // R6

  AST_COMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_valid && (fill != '0) && !push_valid) |=> (fill == RING_LOG2'($past(fill) - 1'b1))); // R6

  AST_DB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    db_req |=> db_valid); // R8

  AST_DB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !db_req |=> !db_valid); // R8

  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_full && comp_valid && (fill != '0)) |=> $stable(fill)); // R9

endmodule

bind trb_ring_mgr trb_ring_chk #(.RING_LOG2(RING_LOG2)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_valid  (push_valid),
  .push_full   (push_full),
  .comp_valid  (comp_valid),
  .fill        (fill),
  .cycle_state (cycle_state),
  .wrap_evt    (wrap_evt),
  .db_req      (db_req),
  .db_valid    (db_valid)
);

// File: tb/tb_trb_ring_mgr.sv
`timescale 1ns/1ps
module tb_trb_ring_mgr;

  localparam int LG   = 2;
  localparam int MASK = (1 << LG) - 1;
  localparam logic [63:0] BASE = 64'h0000_00AB_CDEF_0040;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0;
  logic [63:0]   push_param = '0;
  logic [31:0]   push_status = '0;
  logic [31:0]   push_ctrl = '0;
  logic          push_full;
  logic          comp_valid = 1'b0;
  logic [LG-1:0] fill, remaining, last_idx;
  logic          cycle_state;
  logic          db_req = 1'b0;
  logic [15:0]   db_target = '0, db_stream = '0;
  logic          db_valid;
  logic [31:0]   db_value;
  logic [LG:0]   rd_idx = '0;
  logic [127:0]  rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state
  int m_prod = 0;
  int m_cons = 0;
  bit m_cyc  = 1;

  typedef struct {
    int           idx;
    logic [127:0] data;
    string        req;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  trb_ring_mgr #(.RING_LOG2(LG)) dut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE),
    .push_valid(push_valid), .push_param(push_param), .push_status(push_status),
    .push_ctrl(push_ctrl), .push_full(push_full), .comp_valid(comp_valid),
    .fill(fill), .remaining(remaining), .last_idx(last_idx), .cycle_state(cycle_state),
    .db_req(db_req), .db_target(db_target), .db_stream(db_stream),
    .db_valid(db_valid), .db_value(db_value), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(int typ, logic [6:0] flags);
    logic [31:0] c;
    c = '0;
    c[15:10] = 6'(typ);
    c[6:0]   = flags;
    return c;
  endfunction

  // Driver: predicts what the ring should hold and queues it.
  task automatic push(logic [63:0] p, logic [31:0] s, logic [31:0] c, bit with_comp = 0);
    logic [31:0] cc;
    logic [31:0] jc;
    bit          room;
    @(negedge clk);
    push_valid = 1; push_param = p; push_status = s; push_ctrl = c;
    comp_valid = with_comp;
    room = (m_prod - m_cons) < MASK;
    if (room) begin
      cc = c; cc[0] = m_cyc;
      sbq.push_back('{m_prod % (MASK + 1), {cc, s, p}, "R2"});
      if ((m_prod % (MASK + 1)) == MASK) begin
        jc = ctl(6, 7'b0000010); jc[0] = m_cyc;
        sbq.push_back('{MASK + 1, {jc, 32'h0, BASE}, "R5"});
        m_cyc = ~m_cyc;
      end
      m_prod++;
    end
    if (with_comp && (m_prod - m_cons) > 0) m_cons++;
    @(negedge clk);
    push_valid = 0; comp_valid = 0;
  endtask

  // Monitor: pops expected slot images and compares with the read port.
  task automatic drain();
    exp_t e;
    while (sbq.size() > 0) begin
      e = sbq.pop_front();
      rd_idx = (LG + 1)'(e.idx);
      #1;
      check(e.req, rd_data, e.data);
    end
  endtask

  task automatic complete();
    @(negedge clk);
    comp_valid = 1;
    if (m_prod != m_cons) m_cons++;
    @(negedge clk);
    comp_valid = 0;
  endtask

  task automatic check_state(string req);
    int f;
    f = m_prod - m_cons;
    check({req, " fill"}, 128'(fill), 128'(f));
    check({req, " remaining"}, 128'(remaining), 128'(MASK - f));
    check({req, " last_idx R7"}, 128'(last_idx), 128'((m_cons - 1) & MASK));
    check({req, " cycle"}, 128'(cycle_state), 128'(m_cyc));
    check({req, " full"}, 128'(push_full), 128'(f == MASK));
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check_state("R1");
    for (int i = 0; i <= MASK + 1; i++) begin
      rd_idx = (LG + 1)'(i); #1;
      check("R1 slot clear", rd_data, '0);
    end

    // R2/R3: fill with cycle state 1, input cycle bit 0
    push(64'h1111_0000_0000_0001, 32'h0000_0010, ctl(1, 7'b0100000));
    drain(); check_state("R3 one");
    push(64'h2222_0000_0000_0002, 32'h0000_0020, ctl(2, 7'b1000000));
    push(64'h3333_0000_0000_0003, 32'h0000_0030, ctl(3, 7'b0010000));
    drain(); check_state("R3 three");

    // R4: full ring rejects; slot 3 stays clear
    push(64'hDEAD_BEEF_DEAD_BEEF, 32'hFFFF_FFFF, ctl(4, 7'b0000000));
    drain(); check_state("R4 reject");
    rd_idx = 3'(MASK); #1;
    check("R4 slot untouched", rd_data, '0);

    // R6/R7: retire one, then wrap through slot 3 (R5)
    complete(); check_state("R6 retire");
    push(64'h4444_0000_0000_0004, 32'h0000_0040, ctl(4, 7'b0000000));
    drain(); check_state("R5 wrap1");

    // R6: drain to empty, then complete on empty is ignored
    complete(); complete(); complete();
    check_state("R6 empty");
    complete(); check_state("R6 ignored");

    // R2: cycle state 0, input cycle bit 1 must be cleared
    push(64'h5555_0000_0000_0005, 32'h0000_0050, ctl(8, 7'b0000001));
    push(64'h6666_0000_0000_0006, 32'h0000_0060, ctl(23, 7'b0000001));
    push(64'h7777_0000_0000_0007, 32'h0000_0070, ctl(1, 7'b0110001));
    drain(); check_state("R2 phase0");

    // R9: push and complete together after freeing one slot; second wrap (R5)
    complete();
    push(64'h8888_0000_0000_0008, 32'h0000_0080, ctl(1, 7'b0000001), 1);
    drain(); check_state("R9 both");

    // R8: doorbell
    @(negedge clk);
    db_req = 1; db_target = 16'h0005; db_stream = 16'h1234;
    @(negedge clk);
    db_req = 0;
    check("R8 db_valid", 128'(db_valid), 128'(1));
    check("R8 db_value", 128'(db_value), 128'(32'h1234_0005));
    @(negedge clk);
    check("R8 db pulse ends", 128'(db_valid), 128'(0));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule